// File: doc/BRIEF.md
# Page-Splitting Serial EEPROM Write Sequencer

This block is the host-side controller that turns one write request into the byte-level transactions a serial EEPROM needs. A request carries a start offset and a byte count; the payload arrives on a byte stream with a valid/ready handshake. The sequencer checks the request against the device size and trims it if it runs past the end. It then cuts the request into pieces that never cross a page boundary. Each piece is sent as a one-byte write-enable transaction, followed by a write transaction that carries the opcode, the address and the data.

After each piece the sequencer polls the device status until the device is no longer busy, waiting a fixed interval between busy polls. It gives up with a timeout only when both a minimum number of polls and a minimum elapsed time have been reached. The SPI side is a byte-wide port. The sequencer drives chip select and issues one byte at a time with a go pulse. The port answers each byte with a done pulse, the received byte and a failure flag. The outcome of each request is reported as a one-cycle done or error pulse, together with a result code.

Top module: `eew_wr_seq`

## Requirements
- R1: After reset, and again after every result pulse, `req_ready` is high, `sp_cs` is low and no go, done or error pulse is active.
- R2: A request whose offset is at or beyond `DEV_BYTES`, or whose count is zero, produces an error pulse with code 1 in the cycle after it is accepted. No SPI byte is issued for such a request.
- R3: If offset plus count exceeds `DEV_BYTES`, only `DEV_BYTES - offset` bytes are taken from the data stream and written.
- R4: Every piece is preceded by its own transaction holding the single byte 0x06. The write transaction that follows starts with opcode 0x02.
- R5: Each piece is `min(PAGE_BYTES - offset mod PAGE_BYTES, bytes left)` long, so no write transaction crosses a page.
- R6: The opcode is followed by `ADDR_BYTES` address bytes, most significant first. When `NINE_BIT` is set and the piece offset is at least `2^(8*ADDR_BYTES)`, the opcode becomes 0x0A (bit 3 set).
- R7: After each write transaction the sequencer repeats a two-byte status transaction (0x05, then 0x00). It does so until bit 0 of the second received byte is 0, and only then starts the next piece.
- R8: After a busy status, chip select stays low for at least `CLK_HZ/1000*POLL_MS` cycles before the next status transaction.
- R9: While the device stays busy, the sequencer ends with an error pulse and code 3. This happens only once at least `MIN_POLLS` status reads have returned busy and at least `CLK_HZ/1000*TMO_MS` cycles have passed since the write transaction ended.
- R10: A byte answered with `sp_fail` high stops the request at once. The sequencer gives an error pulse with code 2, drops chip select and issues no further bytes. The pieces already finished remain written, and a new request is accepted afterwards.
- R11: A successful request ends with a done pulse and code 0 in the cycle after the final idle status byte completes. Done and error are never high together and each lasts one cycle.
- R12: `sp_go` is only pulsed while `sp_cs` is high and no earlier byte is outstanding. Chip select is low for at least one cycle between any two transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle; a request is accepted when both are high |
| req_off | input | OFF_W | Start byte offset |
| req_cnt | input | CNT_W | Number of bytes to write |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Payload byte taken when both are high |
| sp_cs | output | 1 | Chip select, active high, held for a whole transaction |
| sp_go | output | 1 | One-cycle request to exchange `sp_tx` |
| sp_tx | output | 8 | Byte to shift out |
| sp_done | input | 1 | One-cycle pulse: byte exchange finished |
| sp_rx | input | 8 | Byte shifted in, valid with `sp_done` |
| sp_fail | input | 1 | Exchange failed, valid with `sp_done` |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| code_o | output | 2 | Result: 0 ok, 1 rejected request, 2 transfer failure, 3 busy timeout |

## Verification
A rejected request has its error pulse due in the cycle right after the accepting edge, so the bench samples at the first falling edge after acceptance. A success pulse is due one cycle after the done of the last idle status byte. The bench stamps that done's cycle number and requires the pulse at exactly the next cycle. The busy timeout must fall between the timeout span and that span plus one poll round, measured from the cycle chip select fell after the write. Poll spacing is counted in low chip-select cycles at each rising edge that follows a busy answer. All sampling happens on falling edges, and inputs change one delay after a rising edge.

// File: rtl/eew_pkg.sv
package eew_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;
  localparam logic [7:0] OP_HIBIT = 8'h08;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_BADREQ = 2'd1,
    RES_XFER   = 2'd2,
    RES_TMO    = 2'd3
  } res_e;

  // bytes that fit before the next page edge, bounded by what is left
  function automatic int unsigned seg_len(int unsigned off, int unsigned left,
                                          int unsigned page);
    int unsigned room;
    room = page - (off % page);
    return (room < left) ? room : left;
  endfunction

  // write opcode, with the extra address bit folded in for 9-bit parts
  function automatic logic [7:0] wr_opcode(int unsigned off, int unsigned abytes,
                                           bit nine);
    if (nine && (off >= (32'd1 << (8 * abytes))))
      return OP_WRITE | OP_HIBIT;
    return OP_WRITE;
  endfunction

endpackage

// File: rtl/eew_reqchk.sv
module eew_reqchk #(
  parameter int OFF_W     = 24,
  parameter int CNT_W     = 16,
  parameter int DEV_BYTES = 2048
) (
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] cnt,
  output logic             bad,
  output logic [CNT_W-1:0] clip
);
  localparam logic [32:0] DEV = 33'(DEV_BYTES);

  logic [32:0] off_x, cnt_x, end_x;
  assign off_x = 33'(off);
  assign cnt_x = 33'(cnt);
  assign end_x = off_x + cnt_x;

  assign bad  = (off_x >= DEV) || (cnt_x == 33'd0);
  assign clip = (end_x > DEV) ? CNT_W'(DEV - off_x) : cnt;
endmodule

// File: rtl/eew_timer.sv
module eew_timer #(
  parameter int POLL_CYC = 125000,
  parameter int TMO_CYC  = 3125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_clr,
  input  logic iv_clr,
  output logic tmo,
  output logic iv_done
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int IW = $clog2(POLL_CYC + 1);

  logic [TW-1:0] elapsed;
  logic [IW-1:0] interval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed  <= '0;
      interval <= '0;
    end else begin
      if (tmo_clr)                          elapsed <= '0;
      else if (elapsed != TW'(TMO_CYC))     elapsed <= elapsed + 1'b1;
      if (iv_clr)                           interval <= '0;
      else if (interval != IW'(POLL_CYC))   interval <= interval + 1'b1;
    end
  end

  assign tmo     = (elapsed >= TW'(TMO_CYC));
  assign iv_done = (interval >= IW'(POLL_CYC - 1));
endmodule

// File: rtl/eew_wr_seq.sv
module eew_wr_seq
  import eew_pkg::*;
#(
  parameter int OFF_W      = 24,
  parameter int CNT_W      = 16,
  parameter int DEV_BYTES  = 2048,
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_BYTES = 2,
  parameter bit NINE_BIT   = 1'b0,
  parameter int CLK_HZ     = 125000000,
  parameter int POLL_MS    = 1,
  parameter int TMO_MS     = 25,
  parameter int MIN_POLLS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             sp_cs,
  output logic             sp_go,
  output logic [7:0]       sp_tx,
  input  logic             sp_done,
  input  logic [7:0]       sp_rx,
  input  logic             sp_fail,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       code_o
);
  localparam int POLL_CYC = CLK_HZ / 1000 * POLL_MS;
  localparam int TMO_CYC  = CLK_HZ / 1000 * TMO_MS;
  localparam int SEG_W    = $clog2(PAGE_BYTES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_WREN, S_WCMD, S_WADR, S_WDAT, S_PCMD, S_PRD, S_PWAIT
  } st_e;

  st_e              st, ret;
  logic             pend;
  logic [OFF_W-1:0] cur_off;
  logic [CNT_W-1:0] rem;
  logic [SEG_W-1:0] seg_left;
  logic [1:0]       aidx;
  logic [15:0]      polls;
  logic [7:0]       tx_byte;
  logic [31:0]      off32;

  // named internal events
  logic req_bad, accept, in_tx, byte_ok, issue, ack;
  logic seg_end, busy_seen, give_up, tmo_clr, iv_clr, tmo, iv_done;
  logic [CNT_W-1:0] req_clip;
  logic rx_unused;

  eew_reqchk #(.OFF_W(OFF_W), .CNT_W(CNT_W), .DEV_BYTES(DEV_BYTES)) u_req (
    .off(req_off), .cnt(req_cnt), .bad(req_bad), .clip(req_clip)
  );

  eew_timer #(.POLL_CYC(POLL_CYC), .TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tmo_clr(tmo_clr), .iv_clr(iv_clr),
    .tmo(tmo), .iv_done(iv_done)
  );

  assign rx_unused = ^sp_rx[7:1];
  assign off32     = 32'(cur_off);
  assign in_tx     = (st == S_WREN) || (st == S_WCMD) || (st == S_WADR) ||
                     (st == S_WDAT) || (st == S_PCMD) || (st == S_PRD);
  assign sp_cs     = in_tx;
  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_ready  = (st == S_WDAT) && !pend;
  assign byte_ok   = (st == S_WDAT) ? wr_valid : 1'b1;
  assign issue     = in_tx && !pend && byte_ok;
  assign ack       = in_tx && pend && sp_done;
  assign seg_end   = ack && !sp_fail && (st == S_WDAT) && (seg_left == SEG_W'(1));
  assign busy_seen = ack && !sp_fail && (st == S_PRD) && sp_rx[0];
  assign give_up   = busy_seen && ((32'(polls) + 1) >= MIN_POLLS) && tmo;
  assign tmo_clr   = seg_end;
  assign iv_clr    = busy_seen && !give_up;

  always_comb begin
    case (st)
      S_WREN:  tx_byte = OP_WREN;
      S_WCMD:  tx_byte = wr_opcode(off32, ADDR_BYTES, NINE_BIT);
      S_WADR:  tx_byte = 8'(off32 >> {aidx, 3'b000});
      S_WDAT:  tx_byte = wr_data;
      S_PCMD:  tx_byte = OP_RDSR;
      default: tx_byte = OP_DUMMY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ret      <= S_IDLE;
      pend     <= 1'b0;
      sp_go    <= 1'b0;
      sp_tx    <= '0;
      cur_off  <= '0;
      rem      <= '0;
      seg_left <= '0;
      aidx     <= '0;
      polls    <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      code_o   <= RES_OK;
    end else begin
      sp_go  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (issue) begin
        sp_go <= 1'b1;
        sp_tx <= tx_byte;
        pend  <= 1'b1;
      end
      if (ack) pend <= 1'b0;

      case (st)
        S_IDLE: if (accept) begin
          if (req_bad) begin
            err_o  <= 1'b1;
            code_o <= RES_BADREQ;
          end else begin
            cur_off <= req_off;
            rem     <= req_clip;
            st      <= S_WREN;
          end
        end
        S_GAP:   st <= ret;
        S_PWAIT: if (iv_done) st <= S_PCMD;
        default: if (ack) begin
          if (sp_fail) begin
            err_o  <= 1'b1;
            code_o <= RES_XFER;
            st     <= S_IDLE;
          end else begin
            case (st)
              S_WREN: begin
                seg_left <= SEG_W'(seg_len(off32, 32'(rem), PAGE_BYTES));
                ret      <= S_WCMD;
                st       <= S_GAP;
              end
              S_WCMD: begin
                aidx <= 2'(ADDR_BYTES - 1);
                st   <= S_WADR;
              end
              S_WADR: begin
                if (aidx == 2'd0) st <= S_WDAT;
                else              aidx <= aidx - 1'b1;
              end
              S_WDAT: begin
                cur_off  <= cur_off + 1'b1;
                rem      <= rem - 1'b1;
                seg_left <= seg_left - 1'b1;
                if (seg_left == SEG_W'(1)) begin
                  polls <= '0;
                  ret   <= S_PCMD;
                  st    <= S_GAP;
                end
              end
              S_PCMD: st <= S_PRD;
              S_PRD: begin
                if (!sp_rx[0]) begin
                  if (rem == '0) begin
                    done_o <= 1'b1;
                    code_o <= RES_OK;
                    st     <= S_IDLE;
                  end else begin
                    ret <= S_WREN;
                    st  <= S_GAP;
                  end
                end else begin
                  if (polls != '1) polls <= polls + 1'b1;
                  if (give_up) begin
                    err_o  <= 1'b1;
                    code_o <= RES_TMO;
                    st     <= S_IDLE;
                  end else begin
                    st <= S_PWAIT;
                  end
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eew_chk.sv
module eew_chk #(
  parameter int MIN_POLLS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_bad,
  input logic        sp_cs,
  input logic        sp_go,
  input logic        sp_done,
  input logic        done_o,
  input logic        err_o,
  input logic [1:0]  code_o,
  input logic [15:0] poll_n
);
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       outst <= 1'b0;
    else if (sp_go)   outst <= 1'b1;
    else if (sp_done) outst <= 1'b0;
  end

  p_idle_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> req_ready);

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bad) |=> (err_o && code_o == 2'd1));

  p_tmo_polls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && code_o == 2'd3) |-> (32'(poll_n) >= MIN_POLLS));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_go_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sp_go |-> sp_cs);

  p_go_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sp_go |-> !outst);

  p_cs_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> sp_cs);
endmodule

bind eew_wr_seq eew_chk #(.MIN_POLLS(MIN_POLLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bad(req_bad), .sp_cs(sp_cs), .sp_go(sp_go), .sp_done(sp_done),
  .done_o(done_o), .err_o(err_o), .code_o(code_o), .poll_n(polls)
);

// File: tb/sim_eew_wr_seq.sv
module sim_eew_wr_seq;
  localparam int DEV  = 512;
  localparam int PAGE = 16;
  localparam int AB   = 1;
  localparam int HZ   = 8000;
  localparam int POLL_CYC = HZ / 1000;
  localparam int TMO_CYC  = HZ / 1000 * 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [23:0] req_off = '0;
  logic [15:0] req_cnt = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b1, wr_ready;
  logic sp_cs, sp_go, sp_done = 1'b0, sp_fail = 1'b0;
  logic [7:0] sp_tx, sp_rx = '0;
  logic done_o, err_o;
  logic [1:0] code_o;

  eew_wr_seq #(.DEV_BYTES(DEV), .PAGE_BYTES(PAGE), .ADDR_BYTES(AB),
               .NINE_BIT(1'b1), .CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_off), .req_cnt(req_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .sp_cs(sp_cs), .sp_go(sp_go), .sp_tx(sp_tx),
    .sp_done(sp_done), .sp_rx(sp_rx), .sp_fail(sp_fail), .done_o(done_o),
    .err_o(err_o), .code_o(code_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [8:0] expq[$];
  logic [7:0] cur[$];
  int lat = 0, busy_left = 0, busy_per = 0, fail_at = -1, n_go = 0;
  int extra_polls = 0, wr_end_cyc = 0, sdone_cyc = 0, low_run = 0, res_cyc = 0;
  int taken = 0, seed = 0;
  bit busy_inf = 0, was_cs = 0, last_busy = 0, took_pend = 0, cmp_en = 1, await = 0;
  bit stat_byte = 0;
  logic [7:0] resp = '0;
  string cur_tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((seed + i * 29) & 255);
  endfunction

  // expected transaction stream; 9'h100 closes a transaction
  task automatic build(int off, int left, int busy_n);
    int o = off, r = left, k = 0;
    while (r > 0) begin
      int room = PAGE - (o % PAGE);
      int s = (room < r) ? room : r;
      expq.push_back(9'h006); expq.push_back(9'h100);
      expq.push_back((o >= (1 << (8 * AB))) ? 9'h00A : 9'h002);
      for (int b = AB - 1; b >= 0; b--) expq.push_back(9'((o >> (8 * b)) & 255));
      for (int j = 0; j < s; j++) expq.push_back({1'b0, pat(k++)});
      expq.push_back(9'h100);
      for (int p = 0; p <= busy_n; p++) begin
        expq.push_back(9'h005); expq.push_back(9'h000); expq.push_back(9'h100);
      end
      o += s;
      r -= s;
    end
  endtask

  task automatic end_tx();
    bit is_poll = (cur.size() == 2) && (cur[0] == 8'h05) && (cur[1] == 8'h00);
    if ((cur[0] & 8'hF7) == 8'h02) begin
      busy_left  = busy_per;
      wr_end_cyc = cyc;
    end
    if (cmp_en) begin
      if (expq.size() == 0) begin
        if (is_poll) extra_polls++;
        else chk(0, {cur_tag, " unexpected transaction"}, cur[0], -1);
      end else begin
        foreach (cur[i]) begin
          logic [8:0] e = (expq.size() != 0) ? expq.pop_front() : 9'h1FF;
          chk(e == {1'b0, cur[i]}, cur_tag, cur[i], e);
        end
        begin
          logic [8:0] e = (expq.size() != 0) ? expq.pop_front() : 9'h1FF;
          chk(e == 9'h100, {cur_tag, " transaction length"}, cur.size(), -1);
        end
      end
    end
    cur.delete();
  endtask

  // byte-port model, data source and per-clock checks, all on falling edges
  always @(negedge clk) begin
    if (took_pend) taken++;
    wr_data   = pat(taken);
    took_pend = wr_ready && wr_valid;
    sp_done = 1'b0;
    sp_fail = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        sp_done = 1'b1;
        sp_rx   = resp;
        sp_fail = (n_go - 1 == fail_at);
        if (stat_byte) begin
          last_busy = resp[0];
          sdone_cyc = cyc;
        end
      end
    end
    if (sp_go) begin
      chk(sp_cs, "R12 byte issued outside chip select", 0, 1);
      cur.push_back(sp_tx);
      n_go++;
      lat = 2;
      stat_byte = (cur.size() == 2) && (cur[0] == 8'h05);
      resp = 8'h00;
      if (stat_byte && (busy_inf || busy_left > 0)) begin
        resp = 8'h01;
        if (!busy_inf) busy_left--;
      end
    end
    if (sp_cs && !was_cs) begin
      if (last_busy) chk(low_run >= POLL_CYC, "R8 poll spacing", low_run, POLL_CYC);
      last_busy = 0;
      low_run = 0;
    end
    if (!sp_cs) low_run++;
    if (!sp_cs && was_cs) end_tx();
    was_cs = sp_cs;
    if ((done_o || err_o) && !await) chk(0, "R11 unexpected result pulse", 1, 0);
  end

  task automatic run(int off, int cnt, int busy_n, int fail_idx, int exp_code,
                     string tag);
    int clip = (off >= DEV || cnt == 0) ? 0 : ((off + cnt > DEV) ? DEV - off : cnt);
    int waited = 0;
    @(posedge clk); #1;
    expq.delete();
    seed = off * 3 + 11;
    build(off, clip, busy_n);
    cur_tag = tag;
    busy_inf = (busy_n < 0);
    busy_per = (busy_n < 0) ? 0 : busy_n;
    busy_left = 0;
    fail_at = fail_idx;
    cmp_en = (fail_idx < 0);
    n_go = 0; extra_polls = 0; taken = 0; took_pend = 0;
    req_off = 24'(off); req_cnt = 16'(cnt); req_valid = 1'b1; await = 1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      waited++;
      if (done_o || err_o || waited > 3000) break;
    end
    res_cyc = cyc;
    chk(waited <= 3000, {tag, " result never came"}, waited, 3000);
    chk((exp_code == 0) ? (done_o && !err_o) : (err_o && !done_o),
        {tag, " pulse kind"}, {done_o, err_o}, (exp_code == 0) ? 2 : 1);
    chk(code_o == 2'(exp_code), {tag, " result code"}, code_o, exp_code);
    if (exp_code == 1) chk(waited == 1, "R2 rejection latency", waited, 1);
    if (exp_code == 0) chk(res_cyc == sdone_cyc + 1, "R11 done latency", res_cyc, sdone_cyc + 1);
    repeat (40) @(posedge clk);
    #1;
    await = 0;
    chk(req_ready && !sp_cs, "R1 idle after result", {req_ready, sp_cs}, 2);
    if (cmp_en) begin
      chk(expq.size() == 0, {tag, " missing transactions"}, expq.size(), 0);
      chk(taken == clip, "R3 bytes taken from stream", taken, clip);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !sp_cs && !sp_go && !done_o && !err_o, "R1 reset state",
        {req_ready, sp_cs, sp_go, done_o, err_o}, 16);
    @(posedge clk); #1;
    rst_n = 1'b1;

    run(512, 4, 0, -1, 1, "R2 offset at device end");
    chk(n_go == 0, "R2 no byte for offset reject", n_go, 0);
    run(5, 0, 0, -1, 1, "R2 zero count");
    chk(n_go == 0, "R2 no byte for zero count", n_go, 0);

    run(32, 5, 2, -1, 0, "R4 R6 R7 single piece with busy polls");
    run(28, 10, 0, -1, 0, "R5 page split");
    run(506, 20, 1, -1, 0, "R3 clipped at end, R6 high opcode");
    chk(taken == 6, "R3 clip length", taken, 6);
    run(254, 4, 0, -1, 0, "R6 ninth address bit across page");

    run(64, 3, -1, -1, 3, "R9 busy timeout");
    chk(extra_polls >= 4, "R9 minimum busy polls", extra_polls, 4);
    chk(res_cyc - wr_end_cyc >= TMO_CYC, "R9 timeout not early", res_cyc - wr_end_cyc, TMO_CYC);
    chk(res_cyc - wr_end_cyc <= TMO_CYC + 40, "R9 timeout not late", res_cyc - wr_end_cyc, TMO_CYC + 40);

    run(16, 20, 0, 23, 2, "R10 transfer failure");
    chk(n_go == 24, "R10 no bytes after failure", n_go, 24);
    chk(taken == 16, "R10 first piece kept", taken, 16);

    run(32, 5, 2, -1, 0, "R10 new request after error");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule